// File: doc/BRIEF.md
# Packed Saturating Halfword Absolute-Value Unit

This block is one slice of a media datapath. A 32-bit operand holds two signed 16-bit lanes, and the block returns the magnitude of each lane on its own. The most negative lane value has no positive counterpart in 16 bits, so the block clamps it to the largest positive value. Every other lane value gets its exact magnitude.

Each operation also updates a media status register. The status register carries a per-lane saturation field, a latest-operation overflow flag, a sticky accumulated-overflow flag and an exception-type field. Two operations can issue in one packet. In that case the second slot's lane field and overflow flag go to a second status register. The accumulated-overflow flag and the exception type are always kept in the first register. A software write port loads either status register, and that write takes precedence over any hardware update of the same register in that cycle.

Results and status appear one clock after the issue. Each result comes with a one-cycle valid pulse.

Top module: `packedAbsSat`

## Requirements
- R1: Each 16-bit lane of an issued operand yields its own absolute value. The result and a valid pulse appear on the clock edge that follows the issue cycle. Examples: 0xFFFF gives 0x0001 and 0x8001 gives 0x7FFF.
- R2: A lane equal to 0x8000 yields 0x7FFF.
- R3: A slot-0 operation with no saturated lane leaves status-0 bits 5:1 cleared. It leaves bit 0 and bits 14:12 as they were.
- R4: A slot-0 operation in which any lane saturates sets status-0 bit 1 (overflow) and bit 0 (accumulated overflow).
- R5: The lane saturation field occupies status bits 5:2. Saturation of the low lane (bits 15:0) sets bit 4, and saturation of the high lane (bits 31:16) sets bit 5. Bits 3:2 are written as zero on every update.
- R6: Any saturation in an issued packet writes the value 1 into status-0 bits 14:12. Otherwise those bits keep their value.
- R7: In a paired issue, slot 1's lane field (bits 5:2) and overflow flag (bit 1) are written to status 1. Slot 1 has its own result and valid pulse.
- R8: In a paired issue, saturation caused only by slot 1 still sets status-0 bit 0 and writes 1 into status-0 bits 14:12.
- R9: Status-0 bit 0 stays set through later non-saturating operations until software writes the register.
- R10: A software write loads the selected status register (select 0 or 1) with the write data. It wins over a hardware update of that register in the same cycle.
- R11: When only slot 0 issues and software does not write status 1, status 1 keeps its value.
- R12: After reset, both results, both valid outputs and both status registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slot0Valid | input | 1 | Slot 0 issues this cycle |
| slot0Operand | input | 32 | Slot 0 packed lanes |
| slot1Valid | input | 1 | Slot 1 issues this cycle, paired with slot 0 |
| slot1Operand | input | 32 | Slot 1 packed lanes |
| swWrEn | input | 1 | Software status write strobe |
| swSel | input | 1 | Selects status register 0 or 1 for the write |
| swData | input | 16 | Value loaded by the software write |
| res0Valid | output | 1 | Slot 0 result valid pulse |
| res0 | output | 32 | Slot 0 packed magnitudes |
| res1Valid | output | 1 | Slot 1 result valid pulse |
| res1 | output | 32 | Slot 1 packed magnitudes |
| stat0 | output | 16 | Status register 0 |
| stat1 | output | 16 | Status register 1 |

## Verification
The checker relies on slot 1 issuing only together with slot 0, because an unpaired second slot has no meaning in a packet. It checks that rule as an input condition. The stimulus never raises the second-slot valid on its own. Apart from that, operands and software writes are unrestricted. The bench clears the status register before each table vector and mixes software writes with issues only in directed cases whose outcome the write-priority rule fixes.

// File: rtl/absunit_pkg.sv
package absunit_pkg;
  localparam int STAT_W     = 16;
  localparam int NUM_SLOTS  = 2;
  localparam int AOVF_BIT   = 0;
  localparam int OVF_BIT    = 1;
  localparam int LANEF_LSB  = 2;
  localparam int LANEF_MSB  = 5;
  localparam int LANEF_W    = LANEF_MSB - LANEF_LSB + 1;
  localparam int XTYPE_LSB  = 12;
  localparam int XTYPE_MSB  = 14;
  localparam int XTYPE_W    = XTYPE_MSB - XTYPE_LSB + 1;
  localparam logic [XTYPE_W-1:0] XTYPE_SAT = 3'd1;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] capture;
  } issueStrobe_t;
endpackage

// File: rtl/satAbsLane.sv
module satAbsLane #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] laneIn,
  output logic [LANE_W-1:0] laneMag,
  output logic              laneSat
);
  localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] ONE      = {{(LANE_W-1){1'b0}}, 1'b1};

  logic isNeg;
  logic [LANE_W-1:0] negated;

  always_comb begin
    isNeg   = laneIn[LANE_W-1];
    negated = ~laneIn + ONE;
    laneSat = (laneIn == MOST_NEG);
    if (laneSat)    laneMag = MOST_POS;
    else if (isNeg) laneMag = negated;
    else            laneMag = laneIn;
  end
endmodule

// File: rtl/absDatapath.sv
module absDatapath
  import absunit_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  issueStrobe_t                         strobe,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]     opIn,
  output logic [NUM_SLOTS-1:0][LANES-1:0]      satLanes,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]     resOut,
  output logic [NUM_SLOTS-1:0]                 resVld
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] magComb;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      satAbsLane #(.LANE_W(LANE_W)) lane_i (
        .laneIn (opIn[s][l*LANE_W +: LANE_W]),
        .laneMag(magComb[s][l*LANE_W +: LANE_W]),
        .laneSat(satLanes[s][l])
      );
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resOut[s] <= '0;
        resVld[s] <= 1'b0;
      end else begin
        resVld[s] <= strobe.capture[s];
        if (strobe.capture[s]) resOut[s] <= magComb[s];
      end
    end
  end
endmodule

// File: rtl/statusCtrl.sv
module statusCtrl
  import absunit_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            slot0Valid,
  input  logic                            slot1Valid,
  input  logic [NUM_SLOTS-1:0][LANES-1:0] satLanes,
  input  logic                            swWrEn,
  input  logic                            swSel,
  input  logic [STAT_W-1:0]               swData,
  output issueStrobe_t                    strobe,
  output logic [STAT_W-1:0]               stat0,
  output logic [STAT_W-1:0]               stat1
);
  localparam int FIELD_BASE = LANEF_W - LANES;

  logic [NUM_SLOTS-1:0]               anySat;
  logic [NUM_SLOTS-1:0][LANEF_W-1:0]  laneField;
  logic [STAT_W-1:0]                  next0, next1;
  logic                               swHit0, swHit1;

  always_comb begin
    strobe.capture[0] = slot0Valid;
    strobe.capture[1] = slot0Valid & slot1Valid;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flags
    always_comb begin
      anySat[s]    = strobe.capture[s] & (|satLanes[s]);
      laneField[s] = '0;
      for (int l = 0; l < LANES; l++)
        laneField[s][FIELD_BASE + l] = strobe.capture[s] & satLanes[s][l];
    end
  end

  always_comb begin
    swHit0 = swWrEn & ~swSel;
    swHit1 = swWrEn & swSel;

    next0 = stat0;
    if (swHit0) begin
      next0 = swData;
    end else if (strobe.capture[0]) begin
      next0[LANEF_MSB:LANEF_LSB] = laneField[0];
      next0[OVF_BIT]             = anySat[0];
      next0[AOVF_BIT]            = stat0[AOVF_BIT] | (|anySat);
      if (|anySat) next0[XTYPE_MSB:XTYPE_LSB] = XTYPE_SAT;
    end

    next1 = stat1;
    if (swHit1) begin
      next1 = swData;
    end else if (strobe.capture[1]) begin
      next1[LANEF_MSB:LANEF_LSB] = laneField[1];
      next1[OVF_BIT]             = anySat[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat0 <= '0;
      stat1 <= '0;
    end else begin
      stat0 <= next0;
      stat1 <= next1;
    end
  end
endmodule

// File: rtl/packedAbsSat.sv
module packedAbsSat
  import absunit_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slot0Valid,
  input  logic [DATA_W-1:0] slot0Operand,
  input  logic              slot1Valid,
  input  logic [DATA_W-1:0] slot1Operand,
  input  logic              swWrEn,
  input  logic              swSel,
  input  logic [STAT_W-1:0] swData,
  output logic              res0Valid,
  output logic [DATA_W-1:0] res0,
  output logic              res1Valid,
  output logic [DATA_W-1:0] res1,
  output logic [STAT_W-1:0] stat0,
  output logic [STAT_W-1:0] stat1
);
  issueStrobe_t                      strobe;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]  opIn;
  logic [NUM_SLOTS-1:0][LANES-1:0]   satLanes;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]  resOut;
  logic [NUM_SLOTS-1:0]              resVld;

  always_comb begin
    opIn[0] = slot0Operand;
    opIn[1] = slot1Operand;
  end

  statusCtrl #(.LANES(LANES)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .slot0Valid(slot0Valid),
    .slot1Valid(slot1Valid),
    .satLanes  (satLanes),
    .swWrEn    (swWrEn),
    .swSel     (swSel),
    .swData    (swData),
    .strobe    (strobe),
    .stat0     (stat0),
    .stat1     (stat1)
  );

  absDatapath #(.LANE_W(LANE_W), .LANES(LANES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opIn    (opIn),
    .satLanes(satLanes),
    .resOut  (resOut),
    .resVld  (resVld)
  );

  assign res0      = resOut[0];
  assign res1      = resOut[1];
  assign res0Valid = resVld[0];
  assign res1Valid = resVld[1];
endmodule

// File: rtl/absSatChecker.sv
module absSatChecker (
  input logic        clk,
  input logic        rstN,
  input logic        slot0Valid,
  input logic [31:0] slot0Operand,
  input logic        slot1Valid,
  input logic [31:0] slot1Operand,
  input logic        swWrEn,
  input logic        swSel,
  input logic [15:0] swData,
  input logic        res0Valid,
  input logic [31:0] res0,
  input logic        res1Valid,
  input logic [31:0] res1,
  input logic [15:0] stat0,
  input logic [15:0] stat1
);
  logic sw0, sw1, sat0Any, sat1Hi;
  assign sw0     = swWrEn && !swSel;
  assign sw1     = swWrEn && swSel;
  assign sat0Any = (slot0Operand[15:0] == 16'h8000) || (slot0Operand[31:16] == 16'h8000);
  assign sat1Hi  = slot1Operand[31:16] == 16'h8000;

  // Input condition: the second slot only issues paired with the first (R7)
  p_pair_issue_r7: assert property (@(posedge clk) disable iff (!rstN)
    slot1Valid |-> slot0Valid);

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    slot0Valid |=> res0Valid);

  p_no_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !slot0Valid |=> !res0Valid);

  p_clamp_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slot0Valid && slot0Operand[15:0] == 16'h8000) |=> res0[15:0] == 16'h7fff);

  p_sat_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (slot0Valid && !sw0 && sat0Any) |=> (stat0[1] && stat0[0]));

  p_xtype_r6: assert property (@(posedge clk) disable iff (!rstN)
    (slot0Valid && !sw0 && sat0Any) |=> stat0[14:12] == 3'd1);

  p_pair_field_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slot0Valid && slot1Valid && !sw1 && sat1Hi) |=> (stat1[5] && stat1[1]));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stat0[0] && !sw0) |=> stat0[0]);

  p_sw_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    sw0 |=> stat0 == $past(swData));

  p_stat1_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!slot1Valid && !sw1) |=> $stable(stat1));
endmodule

bind packedAbsSat absSatChecker chk_i (
  .clk(clk), .rstN(rstN),
  .slot0Valid(slot0Valid), .slot0Operand(slot0Operand),
  .slot1Valid(slot1Valid), .slot1Operand(slot1Operand),
  .swWrEn(swWrEn), .swSel(swSel), .swData(swData),
  .res0Valid(res0Valid), .res0(res0),
  .res1Valid(res1Valid), .res1(res1),
  .stat0(stat0), .stat1(stat1)
);

// File: tb/packedAbsSat_tb_top.sv
module packedAbsSat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {operand, expected result, expected lane field (status bits 5:2)}
  localparam logic [67:0] VECS [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 4'h0},
    {32'h0001_ffff, 32'h0001_0001, 4'h0},
    {32'h7fff_8001, 32'h7fff_7fff, 4'h0},
    {32'h7fff_8000, 32'h7fff_7fff, 4'h4},
    {32'h8000_7fff, 32'h7fff_7fff, 4'h8},
    {32'h8000_8000, 32'h7fff_7fff, 4'hc},
    {32'h1234_5678, 32'h1234_5678, 4'h0},
    {32'hfedc_0000, 32'h0124_0000, 4'h0},
    {32'hffff_8001, 32'h0001_7fff, 4'h0},
    {32'h8000_0001, 32'h7fff_0001, 4'h8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slot0Valid = 1'b0, slot1Valid = 1'b0;
  logic [31:0] slot0Operand = '0, slot1Operand = '0;
  logic swWrEn = 1'b0, swSel = 1'b0;
  logic [15:0] swData = '0;
  logic res0Valid, res1Valid;
  logic [31:0] res0, res1;
  logic [15:0] stat0, stat1;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  packedAbsSat dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One issue cycle, then inputs idle; outputs sampled on the following negedge
  task automatic issue(logic v0, logic [31:0] op0, logic v1, logic [31:0] op1,
                       logic we, logic sel, logic [15:0] data);
    @(negedge clk);
    slot0Valid = v0; slot0Operand = op0;
    slot1Valid = v1; slot1Operand = op1;
    swWrEn = we; swSel = sel; swData = data;
    @(negedge clk);
    slot0Valid = 0; slot1Valid = 0; swWrEn = 0;
  endtask

  function automatic logic [15:0] satStatus(logic [3:0] field);
    return (field != 0) ? (16'(field) << 2) | 16'h1003 : 16'h0000;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 res0", res0, 0);
    check("R12 valids", {res0Valid, res1Valid}, 0);
    check("R12 stat0", stat0, 0);
    check("R12 stat1", stat1, 0);
    rstN = 1'b1;

    // R1 R2 R4 R5 R6: table walk, status cleared before each vector
    for (int i = 0; i < NVEC; i++) begin
      issue(0, 0, 0, 0, 1, 0, 16'h0000);
      issue(1, VECS[i][67:36], 0, 0, 0, 0, 0);
      check("R1 R2 result", res0, VECS[i][35:4]);
      check("R1 valid", res0Valid, 1);
      check("R4 R5 R6 stat0", stat0, satStatus(VECS[i][3:0]));
    end
    @(negedge clk);
    check("R1 valid drops", res0Valid, 0);

    // R3 R9: sticky accumulated overflow through a clean op
    issue(0, 0, 0, 0, 1, 0, 16'h0000);
    issue(1, 32'h7fff_8000, 0, 0, 0, 0, 0);
    issue(1, 32'h0001_0002, 0, 0, 0, 0, 0);
    check("R3 R9 stat0", stat0, 16'h1001);
    check("R3 result", res0, 32'h0001_0002);

    // R10 R11: load stat1, slot-0 only issue leaves it alone
    issue(0, 0, 0, 0, 1, 1, 16'h00a5);
    check("R10 stat1 load", stat1, 16'h00a5);
    issue(1, 32'h8000_8000, 0, 0, 0, 0, 0);
    check("R11 stat1 held", stat1, 16'h00a5);
    check("R11 res1Valid", res1Valid, 0);

    // R7 R8: paired issue, only slot 1 saturates
    issue(0, 0, 0, 0, 1, 0, 16'h0000);
    issue(0, 0, 0, 0, 1, 1, 16'h0000);
    issue(1, 32'h1234_0001, 1, 32'h8000_7fff, 0, 0, 0);
    check("R7 stat1", stat1, 16'h0022);
    check("R7 res1", res1, 32'h7fff_7fff);
    check("R7 res1Valid", res1Valid, 1);
    check("R8 stat0", stat0, 16'h1001);
    check("R8 res0", res0, 32'h1234_0001);

    // R10: software write wins over a saturating update
    issue(1, 32'h8000_8000, 0, 0, 1, 0, 16'h0040);
    check("R10 stat0 priority", stat0, 16'h0040);
    check("R10 result still made", res0, 32'h7fff_7fff);

    report();
  end
endmodule